// File: doc/BRIEF.md
# Indexed Audio Mixer Register Bank

This block holds the control state of an audio mixer behind a two-port host window. Address bit 0 selects the port: with it clear, a write loads an index pointer; with it set, a write stores a byte at the register that the pointer selects. Reads use the same split. The bank has 256 byte locations. Writing any data byte while the pointer is 0 does not store that byte. It restores a fixed set of defaults instead.

Two generations of volume registers share the bank. A write to one member of a linked pair also rewrites its partner in the partner's bit layout. Software that knows only one layout therefore sees consistent values in the other. Reads of locations outside the implemented set return 0xFF.

The block decodes these fields and drives them as outputs:
- per-channel 3-bit attenuation codes for voice, master, FM, CD and line, each with a left and a right code;
- a 2-bit microphone code;
- the playback and capture filter enables;
- the capture filter corner select;
- the stereo flag;
- an encoded input source.

The arithmetic that applies these codes lives elsewhere.

Top module: `mixr_bank`

## Requirements
- R1: A write with `bus_a0`=0 loads the index pointer, and a read with `bus_a0`=0 returns it. The same write also stores the value at location 0x01.
- R2: After hardware reset the outputs show the defaults. The index is 0. Locations 0x04, 0x22, 0x26 and 0x28 hold 0xEE. Every other location holds 0x00.
- R3: A data write while the index is 0 sets 0x04, 0x22, 0x26 and 0x28 to 0xEE and clears 0x0A, 0x0C, 0x0E and 0x2E. It leaves every other location unchanged, including 0x00.
- R4: A data write of v to 0x02, 0x06 or 0x08 stores v there. It also stores {v[3:1],0,v[3:1],0} at the location 0x20 higher.
- R5: A data write of v to 0x22, 0x26 or 0x28 stores v there. It also stores v&0x0E at the location 0x20 lower.
- R6: A data write of v to 0x30, 0x32, 0x36 or 0x38 stores v there. It also stores v&0xEE at the location 0x10 lower.
- R7: A data read returns the stored byte only for 0x00, 0x02, 0x04, 0x06, 0x0A, 0x0C, 0x0E, 0x22, 0x26, 0x28, 0x2E, 0x30, 0x32, 0x36 and 0x38. Every other index reads 0xFF.
- R8: Each volume output pair is bits 7:5 (left) and 3:1 (right) of its location: voice 0x04, master 0x22, FM 0x26, CD 0x28, line 0x2E. `vol_mic` is bits 2:1 of 0x0A.
- R9: `dac_filt_en` is the inverse of bit 5 of 0x0E, and `adc_filt_en` is the inverse of bit 5 of 0x0C. `adc_corner_hi` is bit 3 of 0x0C, and `stereo_en` is bit 1 of 0x0E.
- R10: `src_sel` encodes bits 2:1 of 0x0C. 01 gives 1 (CD), 11 gives 2 (line), and 00 or 10 give 0 (microphone).
- R11: `bus_rdata` is 0x00 whenever `bus_rd` is low.
- R12: The decoded outputs change at the clock edge that takes a data write and hold their value while no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_rd | input | 1 | Host read strobe, never high together with bus_wr |
| bus_a0 | input | 1 | Port select: 0 index, 1 data |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte, combinational |
| vol_voice_l | output | 3 | Voice left code |
| vol_voice_r | output | 3 | Voice right code |
| vol_master_l | output | 3 | Master left code |
| vol_master_r | output | 3 | Master right code |
| vol_fm_l | output | 3 | FM left code |
| vol_fm_r | output | 3 | FM right code |
| vol_cd_l | output | 3 | CD left code |
| vol_cd_r | output | 3 | CD right code |
| vol_line_l | output | 3 | Line left code |
| vol_line_r | output | 3 | Line right code |
| vol_mic | output | 2 | Microphone code |
| dac_filt_en | output | 1 | Playback filter enable |
| adc_filt_en | output | 1 | Capture filter enable |
| adc_corner_hi | output | 1 | Capture filter high corner select |
| stereo_en | output | 1 | Stereo flag |
| src_sel | output | 2 | Input source: 0 mic, 1 CD, 2 line |

## Verification
The bench uses the package defaults: an 8-bit index and a full 256-entry bank. With these values every alias pair, every non-implemented hole and the pointer-0 reset path can be reached by ordinary host cycles. The mirror rules are checked from both sides by reading the partner location back through the data port. The soft reset is checked against a location that an earlier alias had set, so that what the reset leaves alone is observed as well as what it changes.

// File: rtl/mixr_pkg.sv
package mixr_pkg;
  parameter int IDX_W = 8;
  localparam int NREG = 1 << IDX_W;

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [7:0]       byte_t;

  localparam int VOL_W     = 3;
  localparam int VOL_L_LSB = 5;
  localparam int VOL_R_LSB = 1;
  localparam int MIC_W     = 2;
  localparam int MIC_LSB   = 1;

  localparam idx_t A_IDXCPY = idx_t'(8'h01);
  localparam idx_t A_VOICE  = idx_t'(8'h04);
  localparam idx_t A_MIC    = idx_t'(8'h0A);
  localparam idx_t A_INCTL  = idx_t'(8'h0C);
  localparam idx_t A_OUTCTL = idx_t'(8'h0E);
  localparam idx_t A_MASTER = idx_t'(8'h22);
  localparam idx_t A_FM     = idx_t'(8'h26);
  localparam idx_t A_CD     = idx_t'(8'h28);
  localparam idx_t A_LINE   = idx_t'(8'h2E);

  localparam byte_t VOL_DEF = 8'hEE;

  typedef enum logic [1:0] {SRC_MIC = 2'd0, SRC_CD = 2'd1, SRC_LINE = 2'd2} src_e;

  // location is reached by the pointer-0 reset
  function automatic logic in_rst_set(input idx_t a);
    return (a == A_VOICE) || (a == A_MASTER) || (a == A_FM) || (a == A_CD) ||
           (a == A_MIC)   || (a == A_INCTL)  || (a == A_OUTCTL) || (a == A_LINE);
  endfunction

  function automatic byte_t rst_val(input idx_t a);
    if ((a == A_VOICE) || (a == A_MASTER) || (a == A_FM) || (a == A_CD))
      return VOL_DEF;
    return 8'h00;
  endfunction

  function automatic logic is_visible(input idx_t a);
    case (a)
      idx_t'(8'h00), idx_t'(8'h02), idx_t'(8'h04), idx_t'(8'h06),
      idx_t'(8'h0A), idx_t'(8'h0C), idx_t'(8'h0E), idx_t'(8'h22),
      idx_t'(8'h26), idx_t'(8'h28), idx_t'(8'h2E), idx_t'(8'h30),
      idx_t'(8'h32), idx_t'(8'h36), idx_t'(8'h38): return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mixr_wrgen.sv
module mixr_wrgen
  import mixr_pkg::*;
(
  input  logic  wr,
  input  logic  a0,
  input  byte_t wdata,
  input  idx_t  idx,
  output logic  idx_we,
  output logic  soft_rst,
  output logic  pri_we,
  output idx_t  pri_addr,
  output byte_t pri_data,
  output logic  sec_we,
  output idx_t  sec_addr,
  output byte_t sec_data
);
  localparam idx_t OFS20 = idx_t'(8'h20);
  localparam idx_t OFS10 = idx_t'(8'h10);

  logic dat_wr;

  always_comb begin
    idx_we   = wr && !a0;
    dat_wr   = wr && a0;
    soft_rst = dat_wr && (idx == '0);
    pri_we   = idx_we || (dat_wr && (idx != '0));
    pri_addr = idx_we ? A_IDXCPY : idx;
    pri_data = wdata;
    sec_we   = 1'b0;
    sec_addr = idx;
    sec_data = wdata;
    if (dat_wr) begin
      case (idx)
        idx_t'(8'h02), idx_t'(8'h06), idx_t'(8'h08): begin
          sec_we   = 1'b1;
          sec_addr = idx + OFS20;
          sec_data = {wdata[3:1], 1'b0, wdata[3:1], 1'b0};
        end
        idx_t'(8'h22), idx_t'(8'h26), idx_t'(8'h28): begin
          sec_we   = 1'b1;
          sec_addr = idx - OFS20;
          sec_data = wdata & 8'h0E;
        end
        idx_t'(8'h30), idx_t'(8'h32), idx_t'(8'h36), idx_t'(8'h38): begin
          sec_we   = 1'b1;
          sec_addr = idx - OFS10;
          sec_data = wdata & 8'hEE;
        end
        default: sec_we = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/mixr_store.sv
module mixr_store
  import mixr_pkg::*;
#(
  parameter int DEPTH = NREG
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  soft_rst,
  input  logic                  pri_we,
  input  idx_t                  pri_addr,
  input  byte_t                 pri_data,
  input  logic                  sec_we,
  input  idx_t                  sec_addr,
  input  byte_t                 sec_data,
  output logic [DEPTH-1:0][7:0] regs_q
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam idx_t ADDR = idx_t'(i);
    localparam logic RSTM = in_rst_set(ADDR);
    localparam byte_t RV  = rst_val(ADDR);

    byte_t ent_q, ent_d;
    logic  ent_en, hit_r, hit_s, hit_p;

    always_comb begin
      hit_r  = soft_rst && RSTM;
      hit_s  = sec_we && (sec_addr == ADDR);
      hit_p  = pri_we && (pri_addr == ADDR);
      ent_en = hit_r || hit_s || hit_p;
      if (hit_r)      ent_d = RV;
      else if (hit_s) ent_d = sec_data;
      else            ent_d = pri_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= RV;
      else if (ent_en) ent_q <= ent_d;
    end

    assign regs_q[i] = ent_q;
  end
endmodule

// File: rtl/mixr_decode.sv
module mixr_decode
  import mixr_pkg::*;
(
  input  byte_t            r_voice,
  input  byte_t            r_master,
  input  byte_t            r_fm,
  input  byte_t            r_cd,
  input  byte_t            r_line,
  input  byte_t            r_mic,
  input  byte_t            r_inctl,
  input  byte_t            r_outctl,
  output logic [VOL_W-1:0] voice_l,
  output logic [VOL_W-1:0] voice_r,
  output logic [VOL_W-1:0] master_l,
  output logic [VOL_W-1:0] master_r,
  output logic [VOL_W-1:0] fm_l,
  output logic [VOL_W-1:0] fm_r,
  output logic [VOL_W-1:0] cd_l,
  output logic [VOL_W-1:0] cd_r,
  output logic [VOL_W-1:0] line_l,
  output logic [VOL_W-1:0] line_r,
  output logic [MIC_W-1:0] mic,
  output logic             dac_filt,
  output logic             adc_filt,
  output logic             corner_hi,
  output logic             stereo,
  output src_e             src
);
  function automatic logic [VOL_W-1:0] lcode(input byte_t b);
    return b[VOL_L_LSB +: VOL_W];
  endfunction
  function automatic logic [VOL_W-1:0] rcode(input byte_t b);
    return b[VOL_R_LSB +: VOL_W];
  endfunction

  always_comb begin
    voice_l   = lcode(r_voice);   voice_r  = rcode(r_voice);
    master_l  = lcode(r_master);  master_r = rcode(r_master);
    fm_l      = lcode(r_fm);      fm_r     = rcode(r_fm);
    cd_l      = lcode(r_cd);      cd_r     = rcode(r_cd);
    line_l    = lcode(r_line);    line_r   = rcode(r_line);
    mic       = r_mic[MIC_LSB +: MIC_W];
    dac_filt  = !r_outctl[5];
    adc_filt  = !r_inctl[5];
    corner_hi = r_inctl[3];
    stereo    = r_outctl[1];
    case (r_inctl[2:1])
      2'b01:   src = SRC_CD;
      2'b11:   src = SRC_LINE;
      default: src = SRC_MIC;
    endcase
  end
endmodule

// File: rtl/mixr_bank.sv
module mixr_bank
  import mixr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_a0,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic [2:0] vol_voice_l,
  output logic [2:0] vol_voice_r,
  output logic [2:0] vol_master_l,
  output logic [2:0] vol_master_r,
  output logic [2:0] vol_fm_l,
  output logic [2:0] vol_fm_r,
  output logic [2:0] vol_cd_l,
  output logic [2:0] vol_cd_r,
  output logic [2:0] vol_line_l,
  output logic [2:0] vol_line_r,
  output logic [1:0] vol_mic,
  output logic       dac_filt_en,
  output logic       adc_filt_en,
  output logic       adc_corner_hi,
  output logic       stereo_en,
  output logic [1:0] src_sel
);
  idx_t  idx_q, idx_d;
  logic  idx_we, soft_rst, pri_we, sec_we;
  idx_t  pri_addr, sec_addr;
  byte_t pri_data, sec_data;
  logic [NREG-1:0][7:0] regs_q;
  src_e  src;

  mixr_wrgen u_wrgen (
    .wr(bus_wr), .a0(bus_a0), .wdata(bus_wdata), .idx(idx_q),
    .idx_we(idx_we), .soft_rst(soft_rst),
    .pri_we(pri_we), .pri_addr(pri_addr), .pri_data(pri_data),
    .sec_we(sec_we), .sec_addr(sec_addr), .sec_data(sec_data)
  );

  always_comb idx_d = idx_t'(bus_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_we) idx_q <= idx_d;
  end

  mixr_store #(.DEPTH(NREG)) u_store (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .pri_we(pri_we), .pri_addr(pri_addr), .pri_data(pri_data),
    .sec_we(sec_we), .sec_addr(sec_addr), .sec_data(sec_data),
    .regs_q(regs_q)
  );

  mixr_decode u_dec (
    .r_voice(regs_q[A_VOICE]), .r_master(regs_q[A_MASTER]),
    .r_fm(regs_q[A_FM]), .r_cd(regs_q[A_CD]), .r_line(regs_q[A_LINE]),
    .r_mic(regs_q[A_MIC]), .r_inctl(regs_q[A_INCTL]), .r_outctl(regs_q[A_OUTCTL]),
    .voice_l(vol_voice_l), .voice_r(vol_voice_r),
    .master_l(vol_master_l), .master_r(vol_master_r),
    .fm_l(vol_fm_l), .fm_r(vol_fm_r),
    .cd_l(vol_cd_l), .cd_r(vol_cd_r),
    .line_l(vol_line_l), .line_r(vol_line_r),
    .mic(vol_mic), .dac_filt(dac_filt_en), .adc_filt(adc_filt_en),
    .corner_hi(adc_corner_hi), .stereo(stereo_en), .src(src)
  );

  assign src_sel = src;

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      if (!bus_a0)                bus_rdata = 8'(idx_q);
      else if (is_visible(idx_q)) bus_rdata = regs_q[idx_q];
      else                        bus_rdata = 8'hFF;
    end
  end
endmodule

// File: rtl/mixr_bank_chk.sv
module mixr_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       bus_a0,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [2:0] vol_voice_l,
  input logic [2:0] vol_master_l,
  input logic [2:0] vol_master_r,
  input logic       dac_filt_en,
  input logic       stereo_en,
  input logic [1:0] src_sel
);
  logic [7:0] sh_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sh_idx <= 8'h00;
    else if (bus_wr && !bus_a0) sh_idx <= bus_wdata;
  end

  // R1
  idx_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_a0) ##1 (bus_rd && !bus_a0) |-> bus_rdata == $past(bus_wdata));

  // R3
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_a0 && sh_idx == 8'h00) |=>
      (vol_voice_l == 3'd7 && vol_master_r == 3'd7 && src_sel == 2'd0 && !stereo_en));

  // R7
  hole_reads_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_a0 && sh_idx == 8'h01) |-> bus_rdata == 8'hFF);

  // R8
  master_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_a0 && sh_idx == 8'h22) |=>
      (vol_master_l == $past(bus_wdata[7:5]) && vol_master_r == $past(bus_wdata[3:1])));

  // R9
  outctl_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_a0 && sh_idx == 8'h0E) |=>
      (stereo_en == $past(bus_wdata[1]) && dac_filt_en == !$past(bus_wdata[5])));

  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == 8'h00);

  // R12
  hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(vol_master_l) && $stable(stereo_en) && $stable(src_sel)));

  no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
endmodule

bind mixr_bank mixr_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_a0(bus_a0),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vol_voice_l(vol_voice_l),
  .vol_master_l(vol_master_l), .vol_master_r(vol_master_r),
  .dac_filt_en(dac_filt_en), .stereo_en(stereo_en), .src_sel(src_sel)
);

// File: tb/tb_mixr_bank.sv
module tb_mixr_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_a0 = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [2:0] vvl, vvr, vml, vmr, vfl, vfr, vcl, vcr, vll, vlr;
  logic [1:0] vmic, src_sel;
  logic dac_f, adc_f, corner, stereo;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mixr_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_a0(bus_a0),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .vol_voice_l(vvl), .vol_voice_r(vvr), .vol_master_l(vml), .vol_master_r(vmr),
    .vol_fm_l(vfl), .vol_fm_r(vfr), .vol_cd_l(vcl), .vol_cd_r(vcr),
    .vol_line_l(vll), .vol_line_r(vlr), .vol_mic(vmic),
    .dac_filt_en(dac_f), .adc_filt_en(adc_f), .adc_corner_hi(corner),
    .stereo_en(stereo), .src_sel(src_sel)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a0, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_a0 = a0; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic put(input logic [7:0] idx, input logic [7:0] d);
    wr(1'b0, idx);
    wr(1'b1, d);
  endtask

  task automatic rd(input logic a0, output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_a0 = a0;
    #5 v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    wr(1'b0, idx);
    rd(1'b1, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b0, v);
    chk("R2 index after reset", v, 8'h00);
    chk("R2 voice l", 8'(vvl), 8'd7);
    chk("R2 master r", 8'(vmr), 8'd7);
    chk("R2 fm l", 8'(vfl), 8'd7);
    chk("R2 cd r", 8'(vcr), 8'd7);
    chk("R2 line l", 8'(vll), 8'd0);
    chk("R2 mic", 8'(vmic), 8'd0);
    chk("R2 filters", {4'h0, dac_f, adc_f, corner, stereo}, 8'b1100);
    chk("R2 src", 8'(src_sel), 8'd0);
    chk("R11 idle rdata", bus_rdata, 8'h00);
    peek(8'h04, 8'hEE, "R2 loc 0x04");
    peek(8'h2E, 8'h00, "R2 loc 0x2E");
  endtask

  task automatic t_index();
    logic [7:0] v;
    wr(1'b0, 8'h5A);
    rd(1'b0, v);
    chk("R1 index readback", v, 8'h5A);
    rd(1'b1, v);
    chk("R7 hole 0x5A", v, 8'hFF);
    peek(8'h01, 8'hFF, "R7 hole 0x01");
    peek(8'h3A, 8'hFF, "R7 hole 0x3A");
  endtask

  task automatic t_mirror_up();
    put(8'h02, 8'hB7);
    peek(8'h02, 8'hB7, "R4 0x02 stored");
    peek(8'h22, 8'h66, "R4 0x22 mirror");
    chk("R4 master l", 8'(vml), 8'd3);
    chk("R4 master r", 8'(vmr), 8'd3);
    put(8'h06, 8'h0B);
    chk("R4 fm l", 8'(vfl), 8'd5);
    chk("R4 fm r", 8'(vfr), 8'd5);
    put(8'h08, 8'h04);
    chk("R4 cd l", 8'(vcl), 8'd2);
    chk("R4 cd r", 8'(vcr), 8'd2);
    peek(8'h08, 8'hFF, "R7 0x08 hidden");
  endtask

  task automatic t_mirror_down();
    put(8'h22, 8'h5F);
    peek(8'h02, 8'h0E, "R5 0x02 mirror");
    chk("R5 master l", 8'(vml), 8'd2);
    chk("R5 master r", 8'(vmr), 8'd7);
    put(8'h26, 8'hC3);
    peek(8'h06, 8'h02, "R5 0x06 mirror");
    chk("R8 fm l", 8'(vfl), 8'd6);
    chk("R8 fm r", 8'(vfr), 8'd1);
  endtask

  task automatic t_alias10();
    put(8'h32, 8'hFF);
    peek(8'h32, 8'hFF, "R6 0x32 stored");
    peek(8'h22, 8'hEE, "R6 0x22 mirror");
    put(8'h38, 8'h31);
    peek(8'h28, 8'h20, "R6 0x28 mirror");
    chk("R6 cd l", 8'(vcl), 8'd1);
    chk("R6 cd r", 8'(vcr), 8'd0);
    put(8'h30, 8'h12);
    peek(8'h30, 8'h12, "R6 0x30 stored");
  endtask

  task automatic t_decode();
    put(8'h04, 8'hA4);
    chk("R8 voice l", 8'(vvl), 8'd5);
    chk("R8 voice r", 8'(vvr), 8'd2);
    put(8'h2E, 8'h6C);
    chk("R8 line l", 8'(vll), 8'd3);
    chk("R8 line r", 8'(vlr), 8'd6);
    put(8'h0A, 8'h06);
    chk("R8 mic", 8'(vmic), 8'd3);
    put(8'h0C, 8'h2A);
    chk("R9 adc filt off", 8'(adc_f), 8'd0);
    chk("R9 corner hi", 8'(corner), 8'd1);
    chk("R10 src cd", 8'(src_sel), 8'd1);
    put(8'h0C, 8'h06);
    chk("R10 src line", 8'(src_sel), 8'd2);
    chk("R9 adc filt on", 8'(adc_f), 8'd1);
    put(8'h0C, 8'h04);
    chk("R10 src mic for 10", 8'(src_sel), 8'd0);
    // R12: value seen before and after the edge taking the write
    wr(1'b0, 8'h0E);
    @(negedge clk);
    bus_wr = 1'b1; bus_a0 = 1'b1; bus_wdata = 8'h22;
    #5 chk("R12 before edge", 8'(stereo), 8'd0);
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R12 after edge stereo", 8'(stereo), 8'd1);
    chk("R9 dac filt off", 8'(dac_f), 8'd0);
    repeat (3) @(negedge clk);
    chk("R12 held", 8'(stereo), 8'd1);
  endtask

  task automatic t_softreset();
    put(8'h00, 8'h55);
    chk("R3 voice l", 8'(vvl), 8'd7);
    chk("R3 cd l", 8'(vcl), 8'd7);
    chk("R3 line r", 8'(vlr), 8'd0);
    chk("R3 stereo", 8'(stereo), 8'd0);
    chk("R3 src", 8'(src_sel), 8'd0);
    peek(8'h00, 8'h00, "R3 loc 0x00 untouched");
    peek(8'h02, 8'h0E, "R3 loc 0x02 untouched");
    peek(8'h0E, 8'h00, "R3 loc 0x0E cleared");
    peek(8'h26, 8'hEE, "R3 loc 0x26 default");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_index();
    t_mirror_up();
    t_mirror_down();
    t_alias10();
    t_decode();
    t_softreset();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule